// File: doc/BRIEF.md
# HDLC Frame Transmitter with Shared Flags

This block is a synchronous, bit-oriented frame transmitter. Software writes frame bytes into a four-entry transmit FIFO through a small register port. The transmitter sends each byte least significant bit first and inserts a zero after every run of five ones. When the FIFO runs dry at a byte boundary, the frame is closed with a complemented CRC-16 and a flag. Between frames, and whenever nothing is pending, the line carries continuous flags. A bit clock enable input sets the line rate.

There are two ways to close a message. With automatic end-of-message re-arm on, the underrun/EOM interrupt is raised as soon as the FIFO is found empty. Software can then load the next frame while the CRC and the closing flag are still being sent, and that one flag also opens the next frame. With automatic re-arm off, software sees a buffer-empty interrupt only after the CRC is fully sent. It must then write an explicit re-arm command before the transmitter will begin another frame.

Top module: `hdlc_shared_flag_tx`

## Requirements
- R1: With no frame pending, the serial line carries back-to-back flag bytes 0x7E, one bit per bit-clock enable. The first complete flag ends on the 8th enabled bit after reset.
- R2: Frame bytes go out in write order, each byte least significant bit first, and a frame starts only at a flag boundary.
- R3: Inside data and CRC fields, a 0 is inserted after every five consecutive 1s, including a run that ends on the last bit before the closing flag. Flag bits are never stuffed.
- R4: The frame check sequence is CRC-16 with reflected polynomial 0x8408 (x^16+x^12+x^5+1), preset to 0xFFFF and complemented before sending. It is sent low byte first, LSB first.
- R5: When the FIFO is empty at the end of a data byte, the frame ends with the 16 CRC bits followed by one flag.
- R6: With CTRL bit 0 (auto re-arm) set, STATUS bit 0 (underrun/EOM) is set as soon as the FIFO is found empty at the end of a frame, before the CRC has finished.
- R7: Bytes written while a frame is closing are not sent in that frame. If the transmitter is armed and the FIFO holds data when the closing flag ends, the next frame starts right after that flag, so exactly one flag separates the two frames.
- R8: With auto re-arm off, STATUS bit 1 (buffer empty) is set only once all CRC bits are sent. The frame end clears the arm latch (STATUS bit 5), and no new frame starts while it is clear, even if the FIFO holds data.
- R9: Writing CTRL with bit 6 set is the re-arm command. It sets the arm latch and clears STATUS bit 0.
- R10: The FIFO holds 4 bytes, written at address 1. STATUS bit 3 reports full and STATUS bit 4 reports empty. A write while the FIFO is full is dropped and sets STATUS bit 2 (overflow).
- R11: Writing a 1 to STATUS bit 1 or bit 2 (address 2) clears that bit. irq_o is the OR of STATUS bits 0 to 2.
- R12: After reset, txd_o is 1, irq_o is 0, CTRL reads 0 and STATUS (address 2) reads 0x30.
- R13: txd_o changes only on cycles where bit_en_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle enable per serial bit |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 CTRL, 1 DATA, 2 STATUS |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| txd_o | output | 1 | Serial transmit data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench decodes the line: it finds the flags, removes the stuffed zeros, checks the CRC, and compares each frame with the bytes queued when they were written. It writes the next frame the moment the early EOM interrupt appears. If the design let those bytes slip into the closing frame, the decoded frame or its CRC would be wrong. If it waited an extra flag, more than one flag would be counted between the two frames. Test frames contain 0xFF and 0x7E bytes, so a missed or misplaced stuffed zero breaks the decode. In manual mode the bench checks that buffer-empty appears only once all CRC bits have arrived, and that queued bytes stay unsent until the re-arm command. It also overfills the FIFO and checks that only the first four bytes are sent.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W     = 8;
  localparam int CRC_W      = 16;
  localparam int RUN_LIMIT  = 5;
  localparam int FIFO_DEPTH = 4;
  localparam logic [BYTE_W-1:0] FLAG_PATTERN = 8'h7E;
  localparam logic [CRC_W-1:0]  CRC_POLY_R   = 16'h8408;
  localparam logic [CRC_W-1:0]  CRC_PRESET   = 16'hFFFF;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  localparam int CTRL_AUTO = 0;
  localparam int CTRL_CMD  = 6;
  localparam int ST_EOM    = 0;
  localparam int ST_TXE    = 1;
  localparam int ST_OVF    = 2;
  localparam int ST_FULL   = 3;
  localparam int ST_EMPTY  = 4;
  localparam int ST_ARMED  = 5;

  typedef enum logic [1:0] {
    TX_FLAG = 2'd0,
    TX_DATA = 2'd1,
    TX_CRC  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         drop_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign full_o  = (count_q == FULL_CNT);
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign drop_o  = push_i && full_o;
  assign data_o  = mem_q[rd_ptr_q];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[i] <= '0;
      else if (do_push && wr_ptr_q == AW'(i))       mem_q[i] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R10 occupancy never passes depth; a write into a full FIFO changes nothing
  a_r10_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_CNT);
  a_r10_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (count_q == FULL_CNT && $stable(wr_ptr_q)));
endmodule

// File: rtl/hdlc_crc16.sv
module hdlc_crc16 #(
  parameter int               W      = 16,
  parameter logic [W-1:0]     POLY   = 16'h8408,
  parameter logic [W-1:0]     PRESET = 16'hFFFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         upd_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q, stepped;
  logic         fb;

  assign fb      = crc_q[0] ^ bit_i;
  assign stepped = (crc_q >> 1) ^ (fb ? POLY : '0);
  // value including the bit being sent this cycle
  assign crc_o   = upd_i ? stepped : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= PRESET;
    else if (init_i) crc_q <= PRESET;
    else if (upd_i)  crc_q <= stepped;
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              arm_i,
  input  logic              fifo_empty_i,
  input  logic [BYTE_W-1:0] fifo_data_i,
  output logic              fifo_pop_o,
  output logic              underrun_o,
  output logic              crc_done_o,
  output logic              txd_o
);
  localparam int CNT_W = $clog2(CRC_W);
  localparam int RUN_W = $clog2(RUN_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST_CRC  = CNT_W'(CRC_W - 1);

  tx_state_e        state_q;
  logic [CRC_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RUN_W-1:0] ones_q;
  logic             txd_q;

  logic             stuff, out_bit, at_last, step, start_ok;
  logic             crc_init, crc_upd;
  logic [CRC_W-1:0] crc_now;

  assign stuff    = (ones_q == RUN_W'(RUN_LIMIT));
  assign out_bit  = stuff ? 1'b0 : sh_q[0];
  assign at_last  = (cnt_q == ((state_q == TX_CRC) ? LAST_CRC : LAST_BYTE));
  assign step     = bit_en_i && !stuff;
  assign start_ok = !fifo_empty_i && arm_i;
  assign crc_upd  = step && (state_q == TX_DATA);
  assign crc_init = step && at_last && (state_q == TX_FLAG) && start_ok;

  assign fifo_pop_o = step && at_last &&
                      (((state_q == TX_FLAG) && start_ok) ||
                       ((state_q == TX_DATA) && !fifo_empty_i));
  assign underrun_o = step && at_last && (state_q == TX_DATA) && fifo_empty_i;
  assign crc_done_o = step && at_last && (state_q == TX_CRC);
  assign txd_o      = txd_q;

  hdlc_crc16 #(.W(CRC_W), .POLY(CRC_POLY_R), .PRESET(CRC_PRESET)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (crc_init),
    .upd_i  (crc_upd),
    .bit_i  (sh_q[0]),
    .crc_o  (crc_now)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_FLAG;
      sh_q    <= CRC_W'(FLAG_PATTERN);
      cnt_q   <= '0;
      ones_q  <= '0;
      txd_q   <= 1'b1;
    end else if (bit_en_i) begin
      txd_q <= out_bit;
      if (stuff)                  ones_q <= '0;
      else if (state_q == TX_FLAG) ones_q <= '0;
      else                        ones_q <= sh_q[0] ? ones_q + 1'b1 : '0;
      if (step) begin
        if (!at_last) begin
          sh_q  <= sh_q >> 1;
          cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= '0;
          unique case (state_q)
            TX_FLAG: begin
              if (start_ok) begin
                state_q <= TX_DATA;
                sh_q    <= CRC_W'(fifo_data_i);
              end else begin
                sh_q    <= CRC_W'(FLAG_PATTERN);
              end
            end
            TX_DATA: begin
              if (!fifo_empty_i) begin
                sh_q <= CRC_W'(fifo_data_i);
              end else begin
                state_q <= TX_CRC;
                sh_q    <= ~crc_now;
              end
            end
            default: begin
              state_q <= TX_FLAG;
              sh_q    <= CRC_W'(FLAG_PATTERN);
            end
          endcase
        end
      end
    end
  end

  // R3 the run of ones on the line never exceeds the limit
  a_r3_run_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= RUN_W'(RUN_LIMIT));
  // R13 line holds between enables
  a_r13_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(txd_o));
  // R5 CRC field is followed by a flag
  a_r5_crc_then_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_done_o |=> (state_q == TX_FLAG && cnt_q == '0));
  // R8 no frame starts unless armed
  a_r8_start_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_FLAG && !arm_i) |-> !fifo_pop_o);
endmodule

// File: rtl/hdlc_shared_flag_tx.sv
module hdlc_shared_flag_tx
  import hdlc_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              txd_o,
  output logic              irq_o
);
  logic auto_q, armed_q, eom_q, txe_q, ovf_q;
  logic wr_ctrl, wr_data, wr_stat, cmd_rearm;
  logic fifo_empty, fifo_full, fifo_drop, fifo_pop;
  logic underrun, crc_done, arm_eff;
  logic [BYTE_W-1:0] fifo_rd;
  logic unused_wdata;

  assign wr_ctrl   = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign wr_data   = reg_wr_i && (reg_addr_i == ADDR_DATA);
  assign wr_stat   = reg_wr_i && (reg_addr_i == ADDR_STAT);
  assign cmd_rearm = wr_ctrl && reg_wdata_i[CTRL_CMD];
  assign arm_eff   = armed_q || auto_q;
  assign unused_wdata = ^{reg_wdata_i[7], reg_wdata_i[5:3]};

  hdlc_tx_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_data),
    .data_i  (reg_wdata_i),
    .pop_i   (fifo_pop),
    .data_o  (fifo_rd),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .drop_o  (fifo_drop)
  );

  hdlc_tx_framer u_framer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_en_i     (bit_en_i),
    .arm_i        (arm_eff),
    .fifo_empty_i (fifo_empty),
    .fifo_data_i  (fifo_rd),
    .fifo_pop_o   (fifo_pop),
    .underrun_o   (underrun),
    .crc_done_o   (crc_done),
    .txd_o        (txd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q  <= 1'b0;
      armed_q <= 1'b1;
      eom_q   <= 1'b0;
      txe_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (wr_ctrl) auto_q <= reg_wdata_i[CTRL_AUTO];
      if (cmd_rearm)     armed_q <= 1'b1;
      else if (underrun) armed_q <= 1'b0;
      // a new event wins over a clear in the same cycle
      if (underrun && auto_q) eom_q <= 1'b1;
      else if (cmd_rearm)     eom_q <= 1'b0;
      if (crc_done && !auto_q)                    txe_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[ST_TXE])    txe_q <= 1'b0;
      if (fifo_drop)                              ovf_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[ST_OVF])    ovf_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o[CTRL_AUTO] = auto_q;
      ADDR_STAT: begin
        reg_rdata_o[ST_EOM]   = eom_q;
        reg_rdata_o[ST_TXE]   = txe_q;
        reg_rdata_o[ST_OVF]   = ovf_q;
        reg_rdata_o[ST_FULL]  = fifo_full;
        reg_rdata_o[ST_EMPTY] = fifo_empty;
        reg_rdata_o[ST_ARMED] = arm_eff;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = eom_q || txe_q || ovf_q;

  // R6 early EOM in auto mode
  a_r6_eom_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun && auto_q) |=> eom_q);
  // R9 re-arm command clears EOM status
  a_r9_cmd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_rearm && !underrun) |=> (!eom_q && armed_q));
  // R8 buffer-empty in manual mode only after CRC completes
  a_r8_txe_after_crc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txe_q) |-> $past(crc_done && !auto_q));
endmodule

// File: tb/hdlc_shared_flag_tx_tb.sv
module hdlc_shared_flag_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       txd, irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  bit en_run = 0;
  bit tick_d = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_shared_flag_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .txd_o(txd), .irq_o(irq)
  );

  always @(negedge clk) bit_en <= en_run ? ~bit_en : 1'b0;
  always @(posedge clk) tick_d <= bit_en;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_bytes[$];
  int         exp_len[$];
  logic [7:0] rxb[64];

  task automatic queue_byte(input logic [7:0] b);
    exp_bytes.push_back(b);
  endtask

  // line monitor: flag detection, zero removal, frame compare
  bit   acc[$];
  int   ones_r = 0;
  logic [7:0] win = '0;
  int   raw_idx = 0;
  int   first_flag_idx = -1;
  int   frames_rx = 0;
  int   empty_flags = 0;
  int   gap_of[16];

  task automatic frame_check(input int n);
    int nb;
    logic [15:0] c;
    logic fb;
    check(n % 8 == 0, "R3 destuffed length multiple of 8", n % 8, 0);
    nb = n / 8;
    for (int k = 0; k < nb && k < 64; k++)
      for (int i = 0; i < 8; i++) rxb[k][i] = acc[8*k+i];
    c = 16'hFFFF;
    for (int k = 0; k < nb - 2; k++)
      for (int i = 0; i < 8; i++) begin
        fb = c[0] ^ rxb[k][i];
        c  = (c >> 1) ^ (fb ? 16'h8408 : 16'h0000);
      end
    c = ~c;
    check(nb >= 2 && rxb[nb-2] == c[7:0] && rxb[nb-1] == c[15:8], "R4 FCS",
          {rxb[nb-1], rxb[nb-2]}, c);
    if (exp_len.size() == 0) begin
      check(0, "R2 unexpected frame", nb - 2, 0);
    end else begin
      int el;
      el = exp_len.pop_front();
      check(nb - 2 == el, "R5 frame length", nb - 2, el);
      for (int k = 0; k < el; k++) begin
        logic [7:0] eb;
        eb = exp_bytes.pop_front();
        if (k < nb - 2) check(rxb[k] == eb, "R2 frame byte", rxb[k], eb);
      end
    end
    gap_of[frames_rx] = empty_flags;
    empty_flags = 0;
    frames_rx++;
  endtask

  always @(negedge clk) if (tick_d) begin
    raw_idx++;
    win = {txd, win[7:1]};
    if (raw_idx >= 8 && win == 8'h7E) begin
      int n;
      if (first_flag_idx < 0) first_flag_idx = raw_idx;
      n = acc.size() - 7;
      if (n <= 0) empty_flags++;
      else frame_check(n);
      acc.delete();
      ones_r = 0;
    end else if (ones_r == 5 && txd == 1'b0) begin
      ones_r = 0;
    end else begin
      acc.push_back(txd);
      ones_r = txd ? ones_r + 1 : 0;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_stat(input int bitpos, output bit ok);
    logic [7:0] s;
    ok = 0;
    for (int i = 0; i < 4000 && !ok; i++) begin
      rd(2'd2, s);
      ok = s[bitpos];
    end
  endtask

  task automatic wait_frames(input int n, output bit ok);
    ok = 0;
    for (int i = 0; i < 8000 && !ok; i++) begin
      @(negedge clk);
      ok = (frames_rx >= n);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0x%0h expected=0x%0h", WATCHDOG, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    bit ok;
    logic held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    rd(2'd2, s); check(s == 8'h30, "R12 STATUS reset", s, 8'h30);
    rd(2'd0, s); check(s == 8'h00, "R12 CTRL reset", s, 0);
    check(txd == 1'b1, "R12 txd reset", txd, 1);
    check(irq == 1'b0, "R12 irq reset", irq, 0);

    en_run = 1;
    repeat (80) @(negedge clk);
    // R1 idle flags
    check(first_flag_idx == 8, "R1 first flag position", first_flag_idx, 8);
    check(empty_flags >= 4 && frames_rx == 0, "R1 idle flags", empty_flags, 4);

    // auto mode, frame A
    wr(2'd0, 8'h01);
    foreach (s[i]) ; // no-op
    begin
      logic [7:0] fa[4] = '{8'hA5, 8'hFF, 8'h7E, 8'h3F};
      for (int i = 0; i < 4; i++) begin queue_byte(fa[i]); wr(2'd1, fa[i]); end
      exp_len.push_back(4);
    end
    wait_stat(0, ok);
    check(ok, "R6 EOM status set", ok, 1);
    check(frames_rx == 0 && acc.size() < 48, "R6 EOM before CRC done", acc.size(), 32);
    // R7 next frame loaded while CRC/flag go out
    begin
      logic [7:0] fb[4] = '{8'h01, 8'h80, 8'hFF, 8'hFF};
      for (int i = 0; i < 4; i++) begin queue_byte(fb[i]); wr(2'd1, fb[i]); end
      exp_len.push_back(4);
    end
    check(irq == 1'b1, "R11 irq from EOM", irq, 1);
    wr(2'd0, 8'h41);
    rd(2'd2, s); check(s[0] == 1'b0, "R9 command clears EOM", s[0], 0);
    wait_frames(2, ok);
    check(ok && frames_rx == 2, "R7 both frames received", frames_rx, 2);
    check(gap_of[1] == 0, "R7 single shared flag", gap_of[1], 0);

    // manual mode
    wr(2'd0, 8'h00);
    rd(2'd2, s); check(s[5] == 1'b0, "R8 latch cleared by frame end", s[5], 0);
    wr(2'd0, 8'h40);
    rd(2'd2, s); check(s == 8'h30, "R9 re-arm, status idle", s, 8'h30);
    queue_byte(8'h11); wr(2'd1, 8'h11);
    queue_byte(8'h22); wr(2'd1, 8'h22);
    exp_len.push_back(2);
    wait_stat(1, ok);
    check(ok, "R8 buffer-empty set", ok, 1);
    check(frames_rx == 2 && acc.size() >= 32, "R8 buffer-empty after CRC", acc.size(), 32);
    rd(2'd2, s); check(s[0] == 1'b0, "R8 no EOM in manual", s[0], 0);
    // overfill while disarmed
    for (int i = 0; i < 5; i++) begin
      if (i < 4) queue_byte(8'hC0 + 8'(i));
      wr(2'd1, 8'hC0 + 8'(i));
    end
    exp_len.push_back(4);
    repeat (200) @(negedge clk);
    check(frames_rx == 3, "R8 no frame while disarmed", frames_rx, 3);
    rd(2'd2, s); check(s == 8'h0E, "R10 full and overflow", s, 8'h0E);
    check(irq == 1'b1, "R11 irq", irq, 1);
    wr(2'd2, 8'h06);
    rd(2'd2, s); check(s == 8'h08, "R11 W1C", s, 8'h08);
    check(irq == 1'b0, "R11 irq cleared", irq, 0);
    wr(2'd0, 8'h40);
    wait_frames(4, ok);
    check(ok && frames_rx == 4, "R10 four stored bytes sent", frames_rx, 4);
    check(gap_of[3] >= 1, "R8 frame waited for command", gap_of[3], 1);
    check(exp_len.size() == 0, "R2 all frames seen", exp_len.size(), 0);

    // R13 line holds without enable
    en_run = 0;
    repeat (3) @(negedge clk);
    held = txd;
    repeat (20) @(negedge clk);
    check(txd == held, "R13 hold without enable", txd, held);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule